// File: doc/BRIEF.md
# Two-Core Write-Through Cache Pair with Snoop Invalidation

This block joins two processor-side request ports to one shared memory through a private direct-mapped cache per core. Each cache holds one data word per line and writes every store through to memory. A store is one transaction on a shared single-cycle bus. A round-robin arbiter lets only one cache own the bus in any cycle. Each cache watches the bus for stores from its neighbour. When such a store names an address it holds, it drops that line. Its next read of that address then misses and returns the newest value from memory.

A core presents a request while `cX_req_ready` is high. Each request receives exactly one `cX_resp_valid` pulse. A read that hits answers one cycle after acceptance. A read miss or any write first waits in the cache for a bus grant and answers in the cycle after that grant.

Top module: `snoop_cache_pair`

## Requirements
- R1: After reset both ports show ready high and response valid low, every line is invalid, and memory holds zero at every address, so the first read of any address misses and returns 0.
- R2: A read whose address is held in a valid line answers with that line's word exactly one cycle after acceptance, without using the bus.
- R3: A read that misses waits for a bus grant, reads memory, fills the line at index `addr mod LINES` with tag `addr div LINES`, and answers with the memory word in the cycle after the grant (two cycles after acceptance when the bus is free).
- R4: Every write goes to the bus and updates memory and the writer's own line at that index. Its response carries the written word. A later read by the same core hits and returns it.
- R5: A write by one core to an address held by the other core invalidates the other core's line, so the other core's next read of that address misses and returns the new value.
- R6: If a core's read is accepted in the same cycle that the other core's write to the same address is on the bus, the invalidate wins: the read is treated as a miss and returns the newly written value.
- R7: At most one cache owns the bus per cycle. When both wait, the cache not granted last goes first, and the other follows in the next cycle. After reset core 0 has priority.
- R8: Writes by both cores to the same address are put in one order by the bus, and afterwards both cores read the value of the write granted later.
- R9: A neighbour's write to an address with the same index but a different tag leaves the line untouched, so a read of the held address still hits.
- R10: Ready is low from the cycle after a miss or a write is accepted until the response cycle, and a new request is accepted only while ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| c0_req_valid | input | 1 | Core 0 request present |
| c0_req_write | input | 1 | Core 0 request is a write |
| c0_req_addr | input | ADDR_W | Core 0 word address |
| c0_req_wdata | input | DATA_W | Core 0 write word |
| c0_req_ready | output | 1 | Core 0 cache can accept a request |
| c0_resp_valid | output | 1 | Core 0 response pulse |
| c0_resp_rdata | output | DATA_W | Core 0 read word, or the written word for a write |
| c1_req_valid | input | 1 | Core 1 request present |
| c1_req_write | input | 1 | Core 1 request is a write |
| c1_req_addr | input | ADDR_W | Core 1 word address |
| c1_req_wdata | input | DATA_W | Core 1 write word |
| c1_req_ready | output | 1 | Core 1 cache can accept a request |
| c1_resp_valid | output | 1 | Core 1 response pulse |
| c1_resp_rdata | output | DATA_W | Core 1 read word, or the written word for a write |

## Verification
The assertions assume that a core raises its request valid only while its ready is high. A cache that waits for the bus must also keep requesting until it is granted, which is what lets the round-robin check expect the loser to win in the next cycle. The stimulus drives a request only when the bench's own model says that core is idle and the ready it sees agrees. It holds each request for one cycle only. The random phase uses a handful of addresses so that index conflicts, same-address races and snoop hits arise often.

// File: rtl/snoop_cache_pkg.sv
// Shared definitions for the two-core snooping cache pair.
// Assumes exactly two cores share the bus.
package snoop_cache_pkg;
    localparam int NUM_CORES = 2;

    // Controller state of one private cache.
    typedef enum logic {
        CS_IDLE = 1'b0,   // free to take a core request
        CS_WAIT = 1'b1    // holds a miss or a write until the bus is granted
    } cache_state_e;
endpackage

// File: rtl/snoop_bus_arbiter.sv
// Round-robin arbiter for the shared bus between two caches.
// Assumes a requester keeps requesting until it is granted; each grant lasts
// exactly one cycle because every bus transaction completes in one cycle.
module snoop_bus_arbiter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic [1:0] gnt
);
    logic last_q;   // index of the cache granted most recently

    // Grant combinationally: a lone requester wins, a tie goes to the other one.
    always_comb begin
        if (req == 2'b11) gnt = last_q ? 2'b01 : 2'b10;
        else              gnt = req;
    end

    // Remember the latest winner; reset makes core 0 the first favourite.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_q <= 1'b1;
        else if (|gnt)     last_q <= gnt[1];
    end

    a_r7_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r7_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == 2'b00);
    a_r7_loser_next_0: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11 && gnt == 2'b01) |=> gnt == 2'b10);
    a_r7_loser_next_1: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11 && gnt == 2'b10) |=> gnt == 2'b01);
endmodule

// File: rtl/snoop_shared_mem.sv
// Word-addressed shared memory model behind the bus.
// Assumes single-cycle transactions: read data is combinational from the bus
// address, a write lands at the clock edge. Clears to zero on reset.
module snoop_shared_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Read port follows the bus address in the same cycle.
    assign rdata = mem_q[addr];

    // Clear on reset, then store bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    a_r4_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(addr)] == $past(wdata));
endmodule

// File: rtl/snoop_wt_cache.sv
// Direct-mapped write-through cache, one word per line, with snoop invalidate.
// Assumes the core asserts req_valid only while req_ready is high, and that the
// snoop inputs carry the neighbour's granted write in the cycle it is on the bus.
module snoop_wt_cache
    import snoop_cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    cache_state_e      state_q;
    logic              pend_write_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_wdata_q;
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    logic [IDX_W-1:0]  req_idx, snp_idx, pend_idx;
    logic [TAG_W-1:0]  req_tag, snp_tag, pend_tag;
    logic              snoop_same, lookup_hit, snoop_hit;
    logic [DATA_W-1:0] fill_word;

    // Split addresses into index and tag fields.
    assign req_idx  = req_addr[IDX_W-1:0];
    assign req_tag  = req_addr[ADDR_W-1:IDX_W];
    assign snp_idx  = snoop_addr[IDX_W-1:0];
    assign snp_tag  = snoop_addr[ADDR_W-1:IDX_W];
    assign pend_idx = pend_addr_q[IDX_W-1:0];
    assign pend_tag = pend_addr_q[ADDR_W-1:IDX_W];

    // Local lookup and snoop lookup share the same compare; the snoop wins a tie.
    always_comb begin
        snoop_same = snoop_valid && (snoop_addr == req_addr);
        lookup_hit = valid_q[req_idx] && (tag_q[req_idx] == req_tag) && !snoop_same;
        snoop_hit  = snoop_valid && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
        fill_word  = pend_write_q ? pend_wdata_q : mem_rdata;
    end

    // Present the pending transaction to the bus.
    assign req_ready = (state_q == CS_IDLE);
    assign bus_req   = (state_q == CS_WAIT);
    assign bus_write = pend_write_q;
    assign bus_addr  = pend_addr_q;
    assign bus_wdata = pend_wdata_q;

    // Controller, line arrays and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= CS_IDLE;
            valid_q      <= '0;
            resp_valid   <= 1'b0;
            resp_rdata   <= '0;
            pend_write_q <= 1'b0;
            pend_addr_q  <= '0;
            pend_wdata_q <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (snoop_hit) valid_q[snp_idx] <= 1'b0;
            case (state_q)
                CS_IDLE: begin
                    if (req_valid) begin
                        if (!req_write && lookup_hit) begin
                            resp_valid <= 1'b1;
                            resp_rdata <= data_q[req_idx];
                        end else begin
                            pend_write_q <= req_write;
                            pend_addr_q  <= req_addr;
                            pend_wdata_q <= req_wdata;
                            state_q      <= CS_WAIT;
                        end
                    end
                end
                CS_WAIT: begin
                    if (bus_gnt) begin
                        valid_q[pend_idx] <= 1'b1;
                        tag_q[pend_idx]   <= pend_tag;
                        data_q[pend_idx]  <= fill_word;
                        resp_valid        <= 1'b1;
                        resp_rdata        <= fill_word;
                        state_q           <= CS_IDLE;
                    end
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    a_r3_grant_answers: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |=> (resp_valid && req_ready));
    a_r6_snooped_read_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !req_write && snoop_valid && snoop_addr == req_addr)
        |=> (!resp_valid && !req_ready));
    a_r5_line_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && !bus_gnt) |=> !valid_q[$past(snp_idx)]);
    a_r10_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_write) |=> (!req_ready && !resp_valid));
endmodule

// File: rtl/snoop_cache_pair.sv
// Two private write-through caches, one round-robin bus and one shared memory.
// Each cache snoops the other's granted writes. Assumes cores honour ready.
module snoop_cache_pair
    import snoop_cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_req_valid,
    input  logic              c0_req_write,
    input  logic [ADDR_W-1:0] c0_req_addr,
    input  logic [DATA_W-1:0] c0_req_wdata,
    output logic              c0_req_ready,
    output logic              c0_resp_valid,
    output logic [DATA_W-1:0] c0_resp_rdata,
    input  logic              c1_req_valid,
    input  logic              c1_req_write,
    input  logic [ADDR_W-1:0] c1_req_addr,
    input  logic [DATA_W-1:0] c1_req_wdata,
    output logic              c1_req_ready,
    output logic              c1_resp_valid,
    output logic [DATA_W-1:0] c1_resp_rdata
);
    logic [NUM_CORES-1:0] rq_valid, rq_write, rq_ready, rs_valid;
    logic [ADDR_W-1:0]    rq_addr  [NUM_CORES];
    logic [DATA_W-1:0]    rq_wdata [NUM_CORES];
    logic [DATA_W-1:0]    rs_rdata [NUM_CORES];
    logic [NUM_CORES-1:0] b_req, b_gnt, b_write;
    logic [ADDR_W-1:0]    b_addr   [NUM_CORES];
    logic [DATA_W-1:0]    b_wdata  [NUM_CORES];
    logic                 sel_write;
    logic [ADDR_W-1:0]    sel_addr;
    logic [DATA_W-1:0]    sel_wdata, mem_rdata;

    // Gather the per-core ports into arrays.
    always_comb begin
        rq_valid    = {c1_req_valid, c0_req_valid};
        rq_write    = {c1_req_write, c0_req_write};
        rq_addr[0]  = c0_req_addr;
        rq_addr[1]  = c1_req_addr;
        rq_wdata[0] = c0_req_wdata;
        rq_wdata[1] = c1_req_wdata;
    end

    assign c0_req_ready  = rq_ready[0];
    assign c1_req_ready  = rq_ready[1];
    assign c0_resp_valid = rs_valid[0];
    assign c1_resp_valid = rs_valid[1];
    assign c0_resp_rdata = rs_rdata[0];
    assign c1_resp_rdata = rs_rdata[1];

    // Steer the granted cache's transaction onto the shared bus.
    always_comb begin
        sel_write = b_gnt[1] ? b_write[1] : (b_gnt[0] & b_write[0]);
        sel_addr  = b_gnt[1] ? b_addr[1]  : b_addr[0];
        sel_wdata = b_gnt[1] ? b_wdata[1] : b_wdata[0];
    end

    snoop_bus_arbiter u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (b_req),
        .gnt   (b_gnt)
    );

    snoop_shared_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    ((|b_gnt) && sel_write),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (mem_rdata)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        snoop_wt_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_cache (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_valid   (rq_valid[c]),
            .req_write   (rq_write[c]),
            .req_addr    (rq_addr[c]),
            .req_wdata   (rq_wdata[c]),
            .req_ready   (rq_ready[c]),
            .resp_valid  (rs_valid[c]),
            .resp_rdata  (rs_rdata[c]),
            .bus_req     (b_req[c]),
            .bus_gnt     (b_gnt[c]),
            .bus_write   (b_write[c]),
            .bus_addr    (b_addr[c]),
            .bus_wdata   (b_wdata[c]),
            .mem_rdata   (mem_rdata),
            .snoop_valid (b_gnt[NUM_CORES-1-c] && b_write[NUM_CORES-1-c]),
            .snoop_addr  (b_addr[NUM_CORES-1-c])
        );
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (c0_req_ready && c1_req_ready && !c0_resp_valid && !c1_resp_valid));
endmodule

// File: tb/snoop_cache_pair_tb.sv
`timescale 1ns/1ps
module snoop_cache_pair_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] v, w;
    logic [AW-1:0] a [2];
    logic [DW-1:0] d [2];
    logic [1:0] rdy, rv;
    logic [DW-1:0] rd [2];

    always #2 clk = ~clk;

    snoop_cache_pair #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .c0_req_valid(v[0]), .c0_req_write(w[0]), .c0_req_addr(a[0]), .c0_req_wdata(d[0]),
        .c0_req_ready(rdy[0]), .c0_resp_valid(rv[0]), .c0_resp_rdata(rd[0]),
        .c1_req_valid(v[1]), .c1_req_write(w[1]), .c1_req_addr(a[1]), .c1_req_wdata(d[1]),
        .c1_req_ready(rdy[1]), .c1_resp_valid(rv[1]), .c1_resp_rdata(rd[1])
    );

    // Behavioural reference model.
    int mem [256];
    bit mv [2][NL];
    int mt [2][NL];
    int md [2][NL];
    bit busy [2];
    bit pw [2];
    int pa [2];
    int pd [2];
    int last_win;
    bit exp_v [2];
    int exp_d [2];
    bit obs_v [2];
    int obs_d [2];
    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    task automatic note(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Advance the model by one clock edge for the given accepted requests.
    task automatic model_step(input bit iv[2], input bit iw[2], input int ia[2], input int id[2]);
        int g;
        bit bw;
        int ba;
        g = -1;
        if (busy[0] && busy[1]) g = (last_win == 0) ? 1 : 0;
        else if (busy[0]) g = 0;
        else if (busy[1]) g = 1;
        if (g >= 0) last_win = g;
        bw = (g >= 0) && pw[g];
        ba = (g >= 0) ? pa[g] : -1;
        for (int c = 0; c < 2; c++) begin
            exp_v[c] = 0;
            if (busy[c] && g == c) begin
                int val;
                if (pw[c]) begin mem[pa[c]] = pd[c]; val = pd[c]; end
                else val = mem[pa[c]];
                mv[c][pa[c] % NL] = 1; mt[c][pa[c] % NL] = pa[c] / NL; md[c][pa[c] % NL] = val;
                exp_v[c] = 1; exp_d[c] = val; busy[c] = 0;
            end else if (!busy[c] && iv[c]) begin
                bit hit;
                hit = !iw[c] && mv[c][ia[c] % NL] && mt[c][ia[c] % NL] == ia[c] / NL
                      && !(bw && g != c && ba == ia[c]);
                if (hit) begin exp_v[c] = 1; exp_d[c] = md[c][ia[c] % NL]; end
                else begin busy[c] = 1; pw[c] = iw[c]; pa[c] = ia[c]; pd[c] = id[c]; end
            end
        end
        if (bw && mv[1-g][ba % NL] && mt[1-g][ba % NL] == ba / NL) mv[1-g][ba % NL] = 0;
    endtask

    // One cycle: compare outputs at the falling edge, then drive and predict.
    task automatic step(input bit iv[2], input bit iw[2], input int ia[2], input int id[2]);
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            obs_v[c] = rv[c];
            obs_d[c] = int'(rd[c]);
            note(rdy[c] == !busy[c], "R10 ready", int'(rdy[c]), int'(!busy[c]));
            note(rv[c] == exp_v[c], "R2/R3 resp_valid", int'(rv[c]), int'(exp_v[c]));
            if (rv[c] && exp_v[c]) note(int'(rd[c]) == exp_d[c], "R4/R5 resp_rdata", int'(rd[c]), exp_d[c]);
        end
        for (int c = 0; c < 2; c++) begin
            v[c] = iv[c] && !busy[c];
            w[c] = iw[c];
            a[c] = AW'(ia[c]);
            d[c] = DW'(id[c]);
        end
        model_step('{bit'(v[0]), bit'(v[1])}, iw, ia, id);
    endtask

    // Issue up to two requests in one cycle and report each latency and word.
    task automatic pair(input bit iv[2], input bit iw[2], input int ia[2], input int id[2],
                        output int lat[2], output int dat[2]);
        bit done [2];
        step(iv, iw, ia, id);
        for (int c = 0; c < 2; c++) begin done[c] = !iv[c]; lat[c] = 0; dat[c] = 0; end
        for (int k = 1; k <= 10; k++) begin
            step('{0, 0}, '{0, 0}, '{0, 0}, '{0, 0});
            for (int c = 0; c < 2; c++)
                if (!done[c] && obs_v[c]) begin done[c] = 1; lat[c] = k; dat[c] = obs_d[c]; end
            if (done[0] && done[1]) break;
        end
    endtask

    task automatic one(input int c, input bit wr, input int ad, input int wd, output int lat, output int dat);
        bit iv [2];
        bit iw [2];
        int ia [2];
        int id [2];
        int l [2];
        int o [2];
        iv = '{0, 0}; iw = '{0, 0}; ia = '{0, 0}; id = '{0, 0};
        iv[c] = 1; iw[c] = wr; ia[c] = ad; id[c] = wd;
        pair(iv, iw, ia, id, l, o);
        lat = l[c]; dat = o[c];
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : main
        int lat, dat;
        int l [2];
        int o [2];
        v = '0; w = '0; a[0] = '0; a[1] = '0; d[0] = '0; d[1] = '0;
        for (int i = 0; i < 256; i++) mem[i] = 0;
        for (int c = 0; c < 2; c++) begin
            busy[c] = 0; exp_v[c] = 0; exp_d[c] = 0;
            for (int i = 0; i < NL; i++) begin mv[c][i] = 0; mt[c][i] = 0; md[c][i] = 0; end
        end
        last_win = 1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state at the ports
        note(rdy == 2'b11, "R1 ready after reset", int'(rdy), 3);
        note(rv == 2'b00, "R1 no response after reset", int'(rv), 0);

        // Coherence sequence on address 5 (index 1, tag 1).
        one(0, 0, 5, 0, lat, dat);
        note(lat == 2 && dat == 0, "R1/R3 core0 first read misses", lat * 1000 + dat, 2000);
        one(1, 0, 5, 0, lat, dat);
        note(lat == 2 && dat == 0, "R3 core1 first read misses", lat * 1000 + dat, 2000);
        one(0, 0, 5, 0, lat, dat);
        note(lat == 1 && dat == 0, "R2 core0 read hits", lat * 1000 + dat, 1000);
        one(0, 1, 5, 1, lat, dat);
        note(lat == 2 && dat == 1, "R4 core0 write through", lat * 1000 + dat, 2001);
        one(0, 0, 5, 0, lat, dat);
        note(lat == 1 && dat == 1, "R4 core0 own line updated", lat * 1000 + dat, 1001);
        one(1, 0, 5, 0, lat, dat);
        note(lat == 2 && dat == 1, "R5 core1 invalidated and refetches", lat * 1000 + dat, 2001);

        // R6: core1 read accepted while core0's write to 5 is on the bus.
        step('{1, 0}, '{1, 0}, '{5, 0}, '{7, 0});
        pair('{0, 1}, '{0, 0}, '{0, 5}, '{0, 0}, l, o);
        note(l[1] == 2 && o[1] == 7, "R6 invalidate beats same-cycle hit", l[1] * 1000 + o[1], 2007);

        // R9: same index, different tag, does not disturb core1's line.
        one(0, 1, 9, 3, lat, dat);
        one(1, 0, 5, 0, lat, dat);
        note(lat == 1 && dat == 7, "R9 other-tag write leaves line", lat * 1000 + dat, 1007);

        // R7/R8: both write address 20 in the same cycle.
        pair('{1, 1}, '{1, 1}, '{20, 20}, '{17, 34}, l, o);
        note((l[0] == 2 && l[1] == 3) || (l[0] == 3 && l[1] == 2), "R7 serialized grants",
             l[0] * 10 + l[1], 23);
        begin
            int later;
            int lv [2];
            int lo [2];
            later = (l[0] > l[1]) ? 17 : 34;
            pair('{1, 1}, '{0, 0}, '{20, 20}, '{0, 0}, lv, lo);
            note(lo[0] == later, "R8 core0 sees final write", lo[0], later);
            note(lo[1] == later, "R8 core1 sees final write", lo[1], later);
        end

        // Random traffic on a few conflicting addresses, model compared each cycle.
        for (int n = 0; n < 4000; n++) begin
            bit iv [2];
            bit iw [2];
            int ia [2];
            int id [2];
            for (int c = 0; c < 2; c++) begin
                iv[c] = ($urandom % 2) == 0;
                iw[c] = ($urandom % 3) == 0;
                ia[c] = $urandom % 12;
                id[c] = $urandom % 65536;
            end
            step(iv, iw, ia, id);
        end
        repeat (4) step('{0, 0}, '{0, 0}, '{0, 0}, '{0, 0});

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule